// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a one-bit switching demand into two gate enables, one for the high-side switch and one for the low-side switch of a synchronous buck stage. It never lets the two switches conduct at the same time. Each gate driver reports, through a sense flag, when its gate has actually dropped below the turn-on threshold. A gate that is about to rise waits for the opposite gate's flag. The flag must then stay asserted for a programmable number of clock cycles before the gate rises. The dead time therefore follows the real turn-off speed of the drivers and is not a blind timer.

A shutdown input floats the stage: both gates are turned off. When shutdown is released, the sequencer restarts through the same handshake. A force-low input from the fault logic overrides the demand and holds the low side on, again by way of the handshake. An on-time cap limits how long the high side may stay on in one stretch. Once the cap is reached, the demand must drop before the high side can turn on again.

Top module: `adaptive_deadtime_ctrl`

## Requirements
- R1: The high-side enable and the low-side enable are never both 1 in the same cycle.
- R2: From a waiting state, the high-side enable rises at the clock edge on which the low-side sense flag has been sampled 1 for DLY_CYCLES consecutive edges. If the low-side flag first reads 1 L cycles after the low side falls, the stretch with both gates off lasts L+DLY_CYCLES-1 cycles.
- R3: The low-side enable rises by the same rule, counted on the high-side sense flag. The stretch with both gates off is L+DLY_CYCLES-1 cycles.
- R4: If the sense flag of the opposite gate drops to 0 during the wait, the consecutive count restarts from zero.
- R5: While the opposite sense flag stays 0, the waiting gate stays off for as long as that lasts.
- R6: When shutdown is 1 at a clock edge, both enables are 0 after that edge and stay 0 while shutdown is held. After release, the selected gate rises once its opposite flag has been sampled 1 on DLY_CYCLES edges, not counting the first edge after release.
- R7: When forceLow is 1, the high-side enable is 0 from the next cycle on, even with the demand at 1. The low side then turns on through the R3 handshake.
- R8: The high-side enable stays 1 for at most MAX_ON_CYCLES consecutive cycles. After the cap is reached, the low side turns on, and the high side stays off until the demand has been seen at 0.
- R9: During reset both enables are 0. After reset is released with the demand at 0, the low side rises after DLY_CYCLES cycles in which the high-side flag is 1.
- R10: When the demand drops while the high side is on, the high-side enable is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwmDemand | input | 1 | 1 asks for the high side on, 0 asks for the low side on |
| forceLow | input | 1 | Fault request that holds the low side on |
| shutdown | input | 1 | Turns both gates off (stage floats) |
| hsLowSense | input | 1 | 1 when the high-side gate is sensed below threshold |
| lsLowSense | input | 1 | 1 when the low-side gate is sensed below threshold |
| hsGateEn | output | 1 | High-side gate enable |
| lsGateEn | output | 1 | Low-side gate enable |

## Verification
The bench models each driver's sense flag as reporting low a set number of cycles after its enable falls. It sweeps that lag over one to five cycles in both switching directions; the measured gap separates a design that counts the sense flag from one that counts a bare timer. Flags held low tell a safe stall apart from a timeout. A flag that drops briefly shows whether the consecutive count restarts. The shutdown, force-low and on-time-cap sequences each check how the design resumes through the handshake afterwards.

// File: rtl/gate_dt_pkg.sv
package gate_dt_pkg;

  typedef enum logic [2:0] {
    ST_FLOAT   = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4
  } seq_state_t;

  // strobes from the sequencer to the timer datapath
  typedef struct packed {
    logic dlyClr;
    logic dlyRun;
    logic onClr;
    logic onRun;
    logic limSet;
    logic limClr;
  } seq_strobe_t;

endpackage

// File: rtl/gate_timer_dp.sv
module gate_timer_dp
  import gate_dt_pkg::*;
#(
  parameter int DLY_CYCLES    = 4,
  parameter int MAX_ON_CYCLES = 283
) (
  input  logic        clk,
  input  logic        rst_n,
  input  seq_strobe_t stb,
  output logic        dlyDone,
  output logic        onAtMax,
  output logic        limHold
);

  localparam int DLY_W = $clog2(DLY_CYCLES + 1);
  localparam int ON_W  = $clog2(MAX_ON_CYCLES + 1);

  logic [DLY_W-1:0] dlyCnt;
  logic [ON_W-1:0]  onCnt;

  // consecutive sensed-low counter
  always_ff @(posedge clk) begin
    if (!rst_n)          dlyCnt <= '0;
    else if (stb.dlyClr) dlyCnt <= '0;
    else if (stb.dlyRun) dlyCnt <= dlyCnt + 1'b1;
  end

  // high-side on-time counter
  always_ff @(posedge clk) begin
    if (!rst_n)         onCnt <= '0;
    else if (stb.onClr) onCnt <= '0;
    else if (stb.onRun) onCnt <= onCnt + 1'b1;
  end

  // cap latch: set when the cap is hit, cleared once the demand is low
  always_ff @(posedge clk) begin
    if (!rst_n)          limHold <= 1'b0;
    else if (stb.limClr) limHold <= 1'b0;
    else if (stb.limSet) limHold <= 1'b1;
  end

  assign dlyDone = (dlyCnt == DLY_W'(DLY_CYCLES - 1));
  assign onAtMax = (onCnt == ON_W'(MAX_ON_CYCLES - 1));

  a_r4_count_strobes_exclusive : assert property (@(posedge clk) disable iff (!rst_n)
    !(stb.dlyClr && stb.dlyRun));

  a_r8_on_count_bounded : assert property (@(posedge clk) disable iff (!rst_n)
    onCnt < ON_W'(MAX_ON_CYCLES));

  a_r4_dly_count_bounded : assert property (@(posedge clk) disable iff (!rst_n)
    dlyCnt < DLY_W'(DLY_CYCLES));

endmodule

// File: rtl/gate_seq_ctrl.sv
module gate_seq_ctrl
  import gate_dt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwmDemand,
  input  logic        forceLow,
  input  logic        shutdown,
  input  logic        hsLowSense,
  input  logic        lsLowSense,
  input  logic        dlyDone,
  input  logic        onAtMax,
  input  logic        limHold,
  output seq_strobe_t stb,
  output logic        hsGateEn,
  output logic        lsGateEn
);

  seq_state_t state, nextState;
  logic wantHigh;

  assign wantHigh = pwmDemand && !forceLow && !limHold;

  always_comb begin
    nextState  = state;
    stb        = '0;
    stb.limClr = !pwmDemand;
    unique case (state)
      ST_FLOAT: begin
        stb.dlyClr = 1'b1;
        nextState  = wantHigh ? ST_HS_WAIT : ST_LS_WAIT;
      end
      ST_HS_WAIT: begin
        if (!wantHigh) begin
          nextState  = ST_LS_WAIT;
          stb.dlyClr = 1'b1;
        end else if (!lsLowSense) begin
          stb.dlyClr = 1'b1;
        end else if (dlyDone) begin
          nextState = ST_HS_ON;
          stb.onClr = 1'b1;
        end else begin
          stb.dlyRun = 1'b1;
        end
      end
      ST_HS_ON: begin
        if (!wantHigh) begin
          nextState  = ST_LS_WAIT;
          stb.dlyClr = 1'b1;
        end else if (onAtMax) begin
          nextState  = ST_LS_WAIT;
          stb.dlyClr = 1'b1;
          stb.limSet = 1'b1;
        end else begin
          stb.onRun = 1'b1;
        end
      end
      ST_LS_WAIT: begin
        if (wantHigh) begin
          nextState  = ST_HS_WAIT;
          stb.dlyClr = 1'b1;
        end else if (!hsLowSense) begin
          stb.dlyClr = 1'b1;
        end else if (dlyDone) begin
          nextState = ST_LS_ON;
        end else begin
          stb.dlyRun = 1'b1;
        end
      end
      ST_LS_ON: begin
        if (wantHigh) begin
          nextState  = ST_HS_WAIT;
          stb.dlyClr = 1'b1;
        end
      end
      default: begin
        nextState  = ST_FLOAT;
        stb.dlyClr = 1'b1;
      end
    endcase
    if (shutdown) begin
      nextState  = ST_FLOAT;
      stb.dlyClr = 1'b1;
      stb.dlyRun = 1'b0;
      stb.onRun  = 1'b0;
      stb.limSet = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FLOAT;
    else        state <= nextState;
  end

  assign hsGateEn = (state == ST_HS_ON);
  assign lsGateEn = (state == ST_LS_ON);

  // R5: a gate waiting on a flag that reads 0 stays off
  a_r5_stall_holds_hs : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HS_WAIT && !lsLowSense) |=> !hsGateEn);

  a_r5_stall_holds_ls : assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LS_WAIT && !hsLowSense) |=> !lsGateEn);

  // R8: capped high side stays off until demand has dropped
  a_r8_cap_blocks_high : assert property (@(posedge clk) disable iff (!rst_n)
    (limHold && pwmDemand) |=> !hsGateEn);

endmodule

// File: rtl/adaptive_deadtime_ctrl.sv
module adaptive_deadtime_ctrl
  import gate_dt_pkg::*;
#(
  parameter int DLY_CYCLES    = 4,
  parameter int MAX_ON_CYCLES = 283
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwmDemand,
  input  logic forceLow,
  input  logic shutdown,
  input  logic hsLowSense,
  input  logic lsLowSense,
  output logic hsGateEn,
  output logic lsGateEn
);

  seq_strobe_t stb;
  logic dlyDone, onAtMax, limHold;

  gate_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwmDemand (pwmDemand),
    .forceLow  (forceLow),
    .shutdown  (shutdown),
    .hsLowSense(hsLowSense),
    .lsLowSense(lsLowSense),
    .dlyDone   (dlyDone),
    .onAtMax   (onAtMax),
    .limHold   (limHold),
    .stb       (stb),
    .hsGateEn  (hsGateEn),
    .lsGateEn  (lsGateEn)
  );

  gate_timer_dp #(
    .DLY_CYCLES   (DLY_CYCLES),
    .MAX_ON_CYCLES(MAX_ON_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .dlyDone(dlyDone),
    .onAtMax(onAtMax),
    .limHold(limHold)
  );

  a_r1_no_overlap : assert property (@(posedge clk) disable iff (!rst_n)
    !(hsGateEn && lsGateEn));

  a_r2_hs_after_ls_sensed : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsGateEn) |-> $past(lsLowSense));

  a_r3_ls_after_hs_sensed : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lsGateEn) |-> $past(hsLowSense));

  a_r6_shutdown_floats : assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!hsGateEn && !lsGateEn));

  a_r7_force_low_drops_high : assert property (@(posedge clk) disable iff (!rst_n)
    forceLow |=> !hsGateEn);

  a_r10_demand_drop : assert property (@(posedge clk) disable iff (!rst_n)
    (hsGateEn && !pwmDemand) |=> !hsGateEn);

endmodule

// File: tb/adaptive_deadtime_ctrl_test.sv
module adaptive_deadtime_ctrl_test;

  localparam int DLY = 3;
  localparam int MAXON = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwmDemand = 1'b0, forceLow = 1'b0, shutdown = 1'b0;
  logic hsLowSense, lsLowSense;
  logic hsGateEn, lsGateEn;

  int checks = 0, errors = 0, overlaps = 0;
  int lagHs = 1, lagLs = 1, lowHs = 0, lowLs = 0;
  bit stuckHs = 1'b0, stuckLs = 1'b0;

  always #5 clk = ~clk;

  adaptive_deadtime_ctrl #(.DLY_CYCLES(DLY), .MAX_ON_CYCLES(MAXON)) uut (
    .clk(clk), .rst_n(rst_n), .pwmDemand(pwmDemand), .forceLow(forceLow),
    .shutdown(shutdown), .hsLowSense(hsLowSense), .lsLowSense(lsLowSense),
    .hsGateEn(hsGateEn), .lsGateEn(lsGateEn));

  // driver model: a flag reads low a set number of cycles after the gate falls
  always @(negedge clk) begin
    lowHs <= hsGateEn ? 0 : (lowHs < 1000 ? lowHs + 1 : lowHs);
    lowLs <= lsGateEn ? 0 : (lowLs < 1000 ? lowLs + 1 : lowLs);
    if (hsGateEn && lsGateEn) overlaps <= overlaps + 1;
  end
  assign hsLowSense = !stuckHs && (lowHs >= lagHs);
  assign lsLowSense = !stuckLs && (lowLs >= lagLs);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples with both gates off until the chosen gate reads 1
  task automatic gapTo(input bit toHigh, output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (toHigh ? hsGateEn : lsGateEn) return;
      if (!hsGateEn && !lsGateEn) n++;
    end
    n = -1;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, bad;
    repeat (3) @(negedge clk);
    chk(!hsGateEn && !lsGateEn, "R9 reset state", {hsGateEn, lsGateEn}, 0);
    rst_n = 1'b1;
    gapTo(1'b0, n);
    chk(n == DLY, "R9 low side after reset", n, DLY);

    // R2/R3 lag sweep in both directions
    for (int lag = 1; lag <= 5; lag++) begin
      lagLs = lag;
      lagHs = lag;
      repeat (2) @(negedge clk);
      pwmDemand = 1'b1;
      gapTo(1'b1, n);
      chk(n == lag + DLY - 1, "R2 gap to high side", n, lag + DLY - 1);
      repeat (2) @(negedge clk);
      pwmDemand = 1'b0;
      @(negedge clk);
      chk(!hsGateEn, "R10 demand drop", hsGateEn, 0);
      gapTo(1'b0, n);
      chk(n == lag + DLY - 2, "R3 gap to low side", n + 1, lag + DLY - 1);
    end
    lagLs = 2;
    lagHs = 2;

    // R5 stall, then R4 restart
    repeat (2) @(negedge clk);
    stuckLs = 1'b1;
    pwmDemand = 1'b1;
    bad = 0;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      if (hsGateEn) bad++;
    end
    chk(bad == 0, "R5 stall keeps high side off", bad, 0);
    stuckLs = 1'b0;
    @(negedge clk);
    stuckLs = 1'b1;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (hsGateEn) bad++;
    end
    chk(bad == 0, "R4 glitch does not finish count", bad, 0);
    stuckLs = 1'b0;
    gapTo(1'b1, n);
    chk(n == DLY - 1, "R4 count restarted", n, DLY - 1);

    // R8 on-time cap
    n = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!hsGateEn) break;
      n++;
    end
    chk(n == MAXON, "R8 on-time cap", n, MAXON);
    gapTo(1'b0, n);
    chk(n == lagHs + DLY - 2, "R8 low side after cap", n + 1, lagHs + DLY - 1);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (hsGateEn) bad++;
    end
    chk(bad == 0, "R8 high side held off after cap", bad, 0);
    pwmDemand = 1'b0;
    @(negedge clk);
    pwmDemand = 1'b1;
    gapTo(1'b1, n);
    chk(n == lagLs + DLY - 1, "R8 rearm after demand low", n, lagLs + DLY - 1);

    // R7 force low
    @(negedge clk);
    forceLow = 1'b1;
    @(negedge clk);
    chk(!hsGateEn, "R7 force low drops high side", hsGateEn, 0);
    gapTo(1'b0, n);
    chk(n == lagHs + DLY - 2, "R7 low side via handshake", n + 1, lagHs + DLY - 1);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hsGateEn || !lsGateEn) bad++;
    end
    chk(bad == 0, "R7 low side held", bad, 0);
    forceLow = 1'b0;
    gapTo(1'b1, n);
    chk(n == lagLs + DLY - 1, "R7 release resumes high side", n, lagLs + DLY - 1);

    // R6 shutdown
    @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk);
    chk(!hsGateEn && !lsGateEn, "R6 shutdown floats", {hsGateEn, lsGateEn}, 0);
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (hsGateEn || lsGateEn) bad++;
    end
    chk(bad == 0, "R6 float held", bad, 0);
    pwmDemand = 1'b0;
    shutdown = 1'b0;
    gapTo(1'b0, n);
    chk(n == DLY, "R6 restart after release", n, DLY);

    chk(overlaps == 0, "R1 no overlap", overlaps, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule